// File: doc/BRIEF.md
# SPI Byte Exchanger with Sequenced Status Flags

This block is an 8-bit serial peripheral port for a small CPU. It has three byte-wide registers: control, status and data. When the block is enabled in master mode, a CPU write to the data register starts one byte exchange. The block generates the serial clock from the system clock, drives data MSB first and assembles the incoming byte. When the exchange ends, the received byte goes to a receive buffer, and CPU reads of the data register return that buffer. In slave mode the same shift engine runs on an external serial clock while the select input is low.

Three conditions are reported in the status register: exchange complete, write collision and mode fault. None of the flags clears on a single access. Each one needs an ordered pair of register accesses. While the exchange-complete flag is pending, data-register writes are dropped. A write that arrives during an exchange is recorded as a collision and does not disturb the byte in flight. If the select input goes low while the block is a master, the block gives up the bus: it clears its own enable and master bits and stops driving the clock and data pins. An interrupt request combines the exchange-complete and mode-fault flags under an enable bit.

Top module: `spi_seq_flags`

## Requirements
- R1: Register addresses are control = 0, status = 1 and data = 2. After reset, control, status, receive buffer and `irq` are all zero. The status byte has exchange-complete at bit 7, write collision at bit 6 and mode fault at bit 4. Bits 5 and 3..0 always read zero.
- R2: Control bit 6 enables the block and bit 4 selects master mode. In enabled master mode, a data write with no exchange in progress and exchange-complete clear starts one exchange of 8 bits, MSB first. At the end of the exchange, status bit 7 sets and the received byte is readable at address 2.
- R3: Control bit 3 is the clock idle level. Control bit 2 selects the sampling phase: 0 samples on the leading edge, 1 samples on the trailing edge. Control bits 1..0 (value s) set each serial clock half period to 2<<s system clocks. `sclk_out` rests at the idle level outside an exchange.
- R4: Exchange-complete and write-collision clear only when a status read made while either flag is set is followed by a data-register read or write. A data access without that earlier status read leaves both flags unchanged.
- R5: While exchange-complete is set, every data-register write is ignored and starts no exchange. This includes the write that clears the flag.
- R6: A data write while an exchange is in progress sets write collision and leaves the ongoing exchange's transmitted and received bytes unchanged.
- R7: When `sel_n` is low while the block is enabled in master mode, the mode-fault flag sets and the block clears control bits 6 and 4. The exchange is abandoned, and `sclk_drive` and `sdo_drive` go low.
- R8: Mode fault clears only when a status read made while the flag is set is followed by a control-register write. A control write without that earlier status read leaves the flag set.
- R9: `irq` is high exactly when control bit 7 is set and either exchange-complete or mode fault is set.
- R10: When the block is enabled in slave mode (bit 4 = 0) and `sel_n` is low, the block shifts on `sclk_in` edges with the same phase rule. It presents the byte preloaded by a data write on `sdo` and sets exchange-complete after 8 bits, with the received byte in the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 2 | Register address |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (drives flag-clearing sequences) |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for `cpu_addr` (combinational) |
| irq | output | 1 | Interrupt request |
| sclk_in | input | 1 | Serial clock from an external master (slave mode) |
| sclk_out | output | 1 | Generated serial clock (master mode) |
| sclk_drive | output | 1 | Output enable for `sclk_out` |
| sdi | input | 1 | Serial data into the block |
| sdo | output | 1 | Serial data out of the block |
| sdo_drive | output | 1 | Output enable for `sdo` |
| sel_n | input | 1 | Active-low select: slave select in slave mode, fault sense in master mode |

## Verification
The bench targets the ordering rules of the flag-clearing sequences. A data read made without a prior status read must leave the flags set. A design that cleared on any single access would drop exchange-complete there. The bench writes the data register while exchange-complete is pending, both with and without the arming status read, and watches that no clock edges appear. A design that accepted those writes would start a second exchange. It also writes in the middle of an exchange: a design that reloaded the shifter would corrupt the byte the remote device receives, and one that did not record the write would leave write collision clear. Mode fault is raised by pulling `sel_n` low in master mode. The bench then checks that the control bits are stripped, the pins are released and a lone control write does not clear the flag.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    localparam int BYTE_W = 8;
    localparam int RATE_W = 2;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;

    typedef struct packed {
        logic              irq_en;
        logic              enable;
        logic              spare;
        logic              master;
        logic              cpol;
        logic              cpha;
        logic [RATE_W-1:0] rate;
    } ctrl_t;

    typedef struct packed {
        logic done;
        logic wcol;
        logic modf;
    } flags_t;

    function automatic logic [BYTE_W-1:0] stat_byte(flags_t f);
        return {f.done, f.wcol, 1'b0, f.modf, 4'b0000};
    endfunction

endpackage

// File: rtl/spi_seq_divider.sv
module spi_seq_divider #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = (1 << SEL_W) + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    always_comb lim = (CNT_W'(2) << sel) - CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || !run)     cnt <= '0;
        else if (cnt == lim) cnt <= '0;
        else                 cnt <= cnt + CNT_W'(1);
    end

    assign tick = run && (cnt == lim);
endmodule

// File: rtl/spi_seq_engine.sv
module spi_seq_engine #(
    parameter int DW = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           load,
    input  logic [DW-1:0]                  load_val,
    input  logic                           clear,
    input  logic                           step,
    input  logic                           cpha,
    input  logic                           sdi,
    output logic                           sdo,
    output logic [$clog2(2*DW)-1:0]        edge_idx,
    output logic                           done,
    output logic [DW-1:0]                  rx_now
);
    localparam int EW   = $clog2(2*DW);
    localparam int LAST = 2*DW - 1;

    logic [DW-1:0] tx_q;
    logic [DW-1:0] rx_q;
    logic          sample_now;
    logic          shift_now;

    always_comb begin
        sample_now = (edge_idx[0] == cpha);
        shift_now  = !sample_now && !(cpha && edge_idx == '0);
        rx_now     = sample_now ? {rx_q[DW-2:0], sdi} : rx_q;
    end

    assign done = step && (edge_idx == EW'(LAST));
    assign sdo  = tx_q[DW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q     <= '0;
            rx_q     <= '0;
            edge_idx <= '0;
        end else if (load) begin
            tx_q     <= load_val;
            edge_idx <= '0;
        end else if (clear) begin
            edge_idx <= '0;
        end else if (step) begin
            edge_idx <= done ? '0 : edge_idx + EW'(1);
            rx_q     <= rx_now;
            if (shift_now) tx_q <= {tx_q[DW-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/spi_seq_flags.sv
module spi_seq_flags
    import spi_seq_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    cpu_addr,
    input  logic          cpu_wr,
    input  logic          cpu_rd,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          irq,
    input  logic          sclk_in,
    output logic          sclk_out,
    output logic          sclk_drive,
    input  logic          sdi,
    output logic          sdo,
    output logic          sdo_drive,
    input  logic          sel_n
);
    localparam int EW = $clog2(2*DW);

    ctrl_t          ctrl;
    flags_t         flg;
    logic           active, lvl, seq_arm, modf_arm;
    logic [DW-1:0]  rxbuf;
    logic [2:0]     sck_q;
    logic [1:0]     sel_q;
    logic           sel_s;

    logic wr_ctrl, wr_data, rd_stat, rd_data;
    logic fault, tick, m_step, s_step, step, busy, data_ok, start;
    logic eng_done, eng_sdo, eng_clear;
    logic [EW-1:0] edge_idx;
    logic [DW-1:0] rx_now;

    assign sel_s = sel_q[1];

    always_comb begin
        wr_ctrl  = cpu_wr && cpu_addr == A_CTRL;
        wr_data  = cpu_wr && cpu_addr == A_DATA;
        rd_stat  = cpu_rd && cpu_addr == A_STAT;
        rd_data  = cpu_rd && cpu_addr == A_DATA;
        fault    = ctrl.enable && ctrl.master && !sel_s;
        m_step   = active && tick;
        s_step   = ctrl.enable && !ctrl.master && !sel_s && (sck_q[2] ^ sck_q[1]);
        step     = m_step || s_step;
        busy     = active || (edge_idx != '0);
        data_ok  = wr_data && !flg.done && !busy;
        start    = data_ok && ctrl.enable && ctrl.master && !fault;
        eng_clear = fault || (!ctrl.master && sel_s);
    end

    spi_seq_divider #(.SEL_W(RATE_W)) u_div (
        .clk (clk), .rst (rst), .run (active), .sel (ctrl.rate), .tick (tick)
    );

    spi_seq_engine #(.DW(DW)) u_eng (
        .clk (clk), .rst (rst), .load (data_ok), .load_val (cpu_wdata),
        .clear (eng_clear), .step (step), .cpha (ctrl.cpha), .sdi (sdi),
        .sdo (eng_sdo), .edge_idx (edge_idx), .done (eng_done), .rx_now (rx_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= '0;
            sel_q <= 2'b11;
        end else begin
            sck_q <= {sck_q[1:0], sclk_in};
            sel_q <= {sel_q[0], sel_n};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            flg      <= '0;
            active   <= 1'b0;
            lvl      <= 1'b0;
            seq_arm  <= 1'b0;
            modf_arm <= 1'b0;
            rxbuf    <= '0;
        end else begin
            // arming of the two-step clear sequences
            if (rd_stat && (flg.done || flg.wcol)) seq_arm <= 1'b1;
            else if (rd_data || wr_data)           seq_arm <= 1'b0;
            if (rd_stat && flg.modf)               modf_arm <= 1'b1;
            else if (wr_ctrl)                      modf_arm <= 1'b0;

            if (seq_arm && (rd_data || wr_data)) begin
                flg.done <= 1'b0;
                flg.wcol <= 1'b0;
            end
            if (modf_arm && wr_ctrl) flg.modf <= 1'b0;

            if (wr_ctrl) ctrl <= ctrl_t'(cpu_wdata);
            if (wr_data && !flg.done && busy) flg.wcol <= 1'b1;

            if (eng_done) begin
                flg.done <= 1'b1;
                rxbuf    <= rx_now;
                active   <= 1'b0;
            end
            if (start)  active <= 1'b1;
            if (m_step) lvl    <= ~lvl;

            if (fault) begin
                flg.modf    <= 1'b1;
                ctrl.enable <= 1'b0;
                ctrl.master <= 1'b0;
                active      <= 1'b0;
                lvl         <= 1'b0;
            end
        end
    end

    always_comb begin
        case (cpu_addr)
            A_CTRL:  cpu_rdata = ctrl;
            A_STAT:  cpu_rdata = stat_byte(flg);
            A_DATA:  cpu_rdata = rxbuf;
            default: cpu_rdata = '0;
        endcase
    end

    assign irq        = ctrl.irq_en && (flg.done || flg.modf);
    assign sclk_out   = ctrl.cpol ^ lvl;
    assign sclk_drive = ctrl.enable && ctrl.master;
    assign sdo_drive  = ctrl.enable && (ctrl.master || !sel_s);
    assign sdo        = eng_sdo;
endmodule

// File: rtl/spi_seq_checker.sv
module spi_seq_checker
    import spi_seq_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [1:0]  cpu_addr,
    input logic        cpu_wr,
    input logic [7:0]  cpu_rdata,
    input logic        irq,
    input logic        sclk_out,
    input logic        sclk_drive,
    input ctrl_t       ctrl,
    input flags_t      flg,
    input logic        active
);
    a_r1_stat_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr == A_STAT) |-> (cpu_rdata[5] == 1'b0 && cpu_rdata[3:0] == 4'd0));

    a_r5_no_start_while_done: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr == A_DATA && flg.done && !active) |=> !active);

    a_r6_busy_write_collides: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr == A_DATA && active && !flg.done) |=> flg.wcol);

    a_r7_fault_releases_bus: assert property (@(posedge clk) disable iff (rst)
        $rose(flg.modf) |-> (!sclk_drive && !active));

    a_r3_idle_clock_level: assert property (@(posedge clk) disable iff (rst)
        (!active && sclk_drive) |-> (sclk_out == ctrl.cpol));

    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq |-> ctrl.irq_en);
endmodule

bind spi_seq_flags spi_seq_checker u_chk (
    .clk (clk), .rst (rst), .cpu_addr (cpu_addr), .cpu_wr (cpu_wr),
    .cpu_rdata (cpu_rdata), .irq (irq), .sclk_out (sclk_out),
    .sclk_drive (sclk_drive), .ctrl (ctrl), .flg (flg), .active (active)
);

// File: tb/sim_spi_seq_flags.sv
module sim_spi_seq_flags;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cpu_addr = 2'd0;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = 8'd0;
    logic [7:0] cpu_rdata;
    logic       irq, sclk_out, sclk_drive, sdo, sdo_drive;
    logic       sclk_in = 1'b0, sel_n = 1'b1, s_sdi = 1'b0;
    logic       sdi;

    int n_chk = 0, n_bad = 0;

    // remote slave model for master-mode exchanges
    logic       model_on = 1'b0;
    logic       m_cpha = 1'b0;
    logic [7:0] m_tx = 8'd0, m_rx = 8'd0;
    int         k = 0;
    realtime    t0 = 0, t1 = 0;

    always #2 clk = ~clk;

    assign sdi = model_on ? m_tx[7] : s_sdi;

    spi_seq_flags u0 (
        .clk (clk), .rst (rst), .cpu_addr (cpu_addr), .cpu_wr (cpu_wr),
        .cpu_rd (cpu_rd), .cpu_wdata (cpu_wdata), .cpu_rdata (cpu_rdata),
        .irq (irq), .sclk_in (sclk_in), .sclk_out (sclk_out),
        .sclk_drive (sclk_drive), .sdi (sdi), .sdo (sdo),
        .sdo_drive (sdo_drive), .sel_n (sel_n)
    );

    always @(sclk_out) begin
        if (model_on && sclk_drive) begin
            if (k == 0) t0 = $realtime;
            if (k == 1) t1 = $realtime;
            if (k[0] == m_cpha) m_rx = {m_rx[6:0], sdo};
            else if (!(m_cpha && k == 0)) m_tx = {m_tx[6:0], 1'b0};
            k++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk); cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a);
        @(negedge clk); cpu_addr = a; cpu_rd = 1'b1;
        @(negedge clk); cpu_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); cpu_addr = a; #1 d = cpu_rdata;
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 3000 && !irq; i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // {ctrl, byte sent by block, byte sent by remote slave}
    localparam logic [23:0] VEC [4] = '{
        {8'hD0, 8'hA5, 8'h3C},
        {8'hD9, 8'h81, 8'h7E},
        {8'hD6, 8'h1F, 8'hE2},
        {8'hDF, 8'h96, 8'h69}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        summary();
    end

    initial begin
        logic [7:0] d, got;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        peek(2'd0, d); chk("R1 ctrl reset", d, 8'h00);
        peek(2'd1, d); chk("R1 status reset", d, 8'h00);
        peek(2'd2, d); chk("R1 rxbuf reset", d, 8'h00);
        chk("R1 irq reset", irq, 0);
        chk("R1 sclk_drive reset", sclk_drive, 0);

        // table of master exchanges: R2, R3, R4, R9
        for (int v = 0; v < 4; v++) begin
            logic [7:0] c, tx, sb;
            {c, tx, sb} = VEC[v];
            model_on = 1'b0;
            wr(2'd0, c);
            k = 0; m_cpha = c[2]; m_tx = sb; m_rx = 8'd0; model_on = 1'b1;
            wr(2'd2, tx);
            wait_irq();
            @(negedge clk);
            chk("R3 half period", int'((t1 - t0) / 4.0), 2 << c[1:0]);
            chk("R3 toggle count", k, 16);
            chk("R3 idle level", sclk_out, c[3]);
            peek(2'd1, d); chk("R2 done flag", d, 8'h80);
            chk("R9 irq on done", irq, 1);
            peek(2'd2, d); chk("R2 rx byte", d, sb);
            chk("R2 remote got byte", m_rx, tx);
            rd(2'd1); rd(2'd2);
            peek(2'd1, d); chk("R4 cleared by sequence", d, 8'h00);
            chk("R9 irq cleared", irq, 0);
        end

        // R6 write during exchange
        model_on = 1'b0; wr(2'd0, 8'hD0);
        k = 0; m_cpha = 1'b0; m_tx = 8'h3C; m_rx = 8'd0; model_on = 1'b1;
        wr(2'd2, 8'hC3);
        repeat (10) @(negedge clk);
        wr(2'd2, 8'hFF);
        wait_irq(); @(negedge clk);
        peek(2'd1, d); chk("R6 collision flagged", d, 8'hC0);
        chk("R6 remote byte intact", m_rx, 8'hC3);
        peek(2'd2, d); chk("R6 rx intact", d, 8'h3C);
        rd(2'd1); rd(2'd2);
        peek(2'd1, d); chk("R6 wcol cleared by R4 sequence", d, 8'h00);

        // R5 write ignored while done pending, R4 order matters
        k = 0; m_tx = 8'h55;
        wr(2'd2, 8'h11);
        wait_irq(); @(negedge clk);
        k = 0;
        wr(2'd2, 8'h5A);
        repeat (60) @(negedge clk);
        chk("R5 no exchange while done", k, 0);
        peek(2'd1, d); chk("R5 done still set", d, 8'h80);
        rd(2'd2);
        peek(2'd1, d); chk("R4 data read alone keeps flag", d, 8'h80);
        rd(2'd1);
        wr(2'd2, 8'h22);
        peek(2'd1, d); chk("R4 status then write clears", d, 8'h00);
        repeat (60) @(negedge clk);
        chk("R5 clearing write ignored", k, 0);
        model_on = 1'b0;

        // R7/R8 mode fault
        wr(2'd0, 8'hD0);
        sel_n = 1'b0;
        repeat (6) @(negedge clk);
        peek(2'd1, d); chk("R7 modf set", d, 8'h10);
        peek(2'd0, d); chk("R7 ctrl stripped", d, 8'h80);
        chk("R7 sclk released", sclk_drive, 0);
        chk("R7 sdo released", sdo_drive, 0);
        chk("R9 irq on modf", irq, 1);
        sel_n = 1'b1;
        repeat (4) @(negedge clk);
        wr(2'd0, 8'h80);
        peek(2'd1, d); chk("R8 ctrl write alone keeps modf", d, 8'h10);
        rd(2'd1);
        wr(2'd0, 8'h80);
        peek(2'd1, d); chk("R8 modf cleared", d, 8'h00);
        chk("R9 irq low after clear", irq, 0);

        // R10 slave mode, CPOL=0 CPHA=0, irq disabled
        wr(2'd0, 8'h40);
        wr(2'd2, 8'hA5);
        sel_n = 1'b0; got = 8'd0;
        for (int i = 0; i < 8; i++) begin
            s_sdi = 8'h96 >> (7 - i);
            repeat (8) @(negedge clk);
            sclk_in = 1'b1;
            repeat (4) @(negedge clk);
            got = {got[6:0], sdo};
            if (i == 0) chk("R10 sdo driven when selected", sdo_drive, 1);
            repeat (4) @(negedge clk);
            sclk_in = 1'b0;
        end
        repeat (8) @(negedge clk);
        peek(2'd1, d); chk("R10 slave done", d, 8'h80);
        peek(2'd2, d); chk("R10 slave rx", d, 8'h96);
        chk("R10 slave tx", got, 8'hA5);
        chk("R9 irq masked", irq, 0);
        sel_n = 1'b1;

        summary();
    end
endmodule